// File: doc/BRIEF.md
# Root Pointer Decode and Limit Check

This block takes one step of an address translation. It reads a 64-bit root pointer, the table index taken from the logical address, the full logical address and a flag that turns function-code lookup on. From these it produces one of three results. The first is the physical address of the next-level table entry. The second is a direct-mapped physical page address. The third is a fault, which reports either an invalid descriptor or an index that lies outside the pointer's bound.

The pointer fields that the block uses are fixed:

- bit 63 selects the bound sense;
- bits 62..48 hold a 15-bit unsigned bound;
- bits 33..32 hold the descriptor type;
- bits 31..4 hold the table base, or the constant offset for a direct-mapped pointer.

Bits 3..0 are ignored, and so are all other bits. The decode itself is combinational. A parameter can add one registered output stage, and the block sits behind a valid/ready handshake on each side.

Top module: `rootptr_xlate`

## Requirements
- R1: Descriptor type 0 yields out_kind = 2 (fault), out_fault = 2'b01 (bit 0 = invalid) and out_addr = 0.
- R2: When bit 63 is 0, an index greater than the bound is a limit fault: out_kind = 2, out_fault = 2'b10 (bit 1 = limit), out_addr = 0. An index less than or equal to the bound passes.
- R3: When bit 63 is 1, an index less than the bound is a limit fault with the same encoding as in R2. An index greater than or equal to the bound passes.
- R4: Descriptor type 1 yields out_kind = 1 (page) and out_addr = logical address + {ptr[31:4], 4'b0000}, taken modulo 2^32.
- R5: Descriptor type 2 yields out_kind = 0 (table) and out_addr = {ptr[31:4], 4'b0000} + 4 * index, taken modulo 2^32.
- R6: Descriptor type 3 yields out_kind = 0 and out_addr = {ptr[31:4], 4'b0000} + 8 * index, taken modulo 2^32.
- R7: With function-code lookup on, no limit fault is raised for descriptor types 2 and 3. For type 1 the bound is still checked.
- R8: An upper bound of 0x7FFF, or a lower bound of 0, never raises a limit fault.
- R9: Pointer bits 3..0 and 47..34 have no effect on any output.
- R10: An invalid descriptor whose index would also break the bound reports only the invalid bit, 2'b01.
- R11: With the registered stage, a result appears one cycle after acceptance. in_ready = !out_valid || out_ready. A result stays unchanged while out_valid is high and out_ready is low.
- R12: During reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle |
| in_ptr | input | 64 | Root pointer value |
| in_index | input | IDX_W | Table index from the logical address |
| in_laddr | input | ADDR_W | Full logical address |
| in_fcl_en | input | 1 | Function-code lookup enabled |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_kind | output | 2 | 0 table entry, 1 page, 2 fault |
| out_addr | output | ADDR_W | Entry or page address, 0 on fault |
| out_fault | output | 2 | Bit 0 invalid, bit 1 limit violation |

## Verification
The hardest cases to reach from the ports are the ones where two rules compete for the same request:

- an invalid type whose index is also out of bound;
- function-code lookup on while the type is direct-mapped;
- a bound sitting at its suppression value.

Random pointers almost never line these up. The stimulus therefore first sends directed pointers built field by field, with the index placed exactly at the bound and one step past it. It then sends a random sweep while out_ready follows a stalling pattern, so that each result is also checked for holding steady under back-pressure.

// File: rtl/rootptr_pkg.sv
package rootptr_pkg;
   localparam int PTR_W     = 64;
   localparam int LIM_W     = 15;
   localparam int SENSE_BIT = 63;
   localparam int LIM_LSB   = 48;
   localparam int DT_LSB    = 32;
   localparam int BASE_LSB  = 4;
   localparam int FLT_W     = 2;
   localparam int FLT_INV   = 0;
   localparam int FLT_LIM   = 1;

   typedef enum logic [1:0] {
      DT_INVALID = 2'd0,
      DT_PAGE    = 2'd1,
      DT_SHORT   = 2'd2,
      DT_LONG    = 2'd3
   } dtype_e;

   typedef enum logic [1:0] {
      KIND_TABLE = 2'd0,
      KIND_PAGE  = 2'd1,
      KIND_FAULT = 2'd2
   } kind_e;
endpackage

// File: rtl/rootptr_fields.sv
module rootptr_fields
   import rootptr_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [PTR_W-1:0]  ptr,
   output dtype_e            dt,
   output logic              sense_lo,
   output logic [LIM_W-1:0]  limit,
   output logic [ADDR_W-1:0] base
);
   assign dt       = dtype_e'(ptr[DT_LSB +: 2]);
   assign sense_lo = ptr[SENSE_BIT];
   assign limit    = ptr[LIM_LSB +: LIM_W];
   assign base     = {ptr[ADDR_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
endmodule

// File: rtl/rootptr_bound.sv
module rootptr_bound
   import rootptr_pkg::*;
#(
   parameter int IDX_W = 15
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [LIM_W-1:0] limit,
   input  logic             sense_lo,
   input  dtype_e           dt,
   input  logic             fcl_en,
   output logic             violation
);
   localparam int CMP_W = (IDX_W > LIM_W) ? IDX_W : LIM_W;

   logic [CMP_W-1:0] idx_x;
   logic [CMP_W-1:0] lim_x;
   logic             check_on;

   assign idx_x    = CMP_W'(idx);
   assign lim_x    = CMP_W'(limit);
   // direct-mapped pointers are always bounded
   assign check_on = !(fcl_en && (dt != DT_PAGE));

   always_comb begin
      if (!check_on)     violation = 1'b0;
      else if (sense_lo) violation = (idx_x < lim_x);
      else               violation = (idx_x > lim_x);
   end
endmodule

// File: rtl/rootptr_addr.sv
module rootptr_addr
   import rootptr_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 15
) (
   input  dtype_e            dt,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] laddr,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr
);
   localparam int SHIFT_SHORT = 2;
   localparam int SHIFT_LONG  = 3;

   logic [ADDR_W-1:0] idx_ext;
   logic [ADDR_W-1:0] sum_short;
   logic [ADDR_W-1:0] sum_long;
   logic [ADDR_W-1:0] sum_page;

   assign idx_ext   = ADDR_W'(idx);
   assign sum_short = base + (idx_ext << SHIFT_SHORT);
   assign sum_long  = base + (idx_ext << SHIFT_LONG);
   assign sum_page  = laddr + base;

   always_comb begin
      unique case (dt)
         DT_PAGE:  addr = sum_page;
         DT_SHORT: addr = sum_short;
         DT_LONG:  addr = sum_long;
         default:  addr = '0;
      endcase
   end
endmodule

// File: rtl/rootptr_xlate.sv
module rootptr_xlate
   import rootptr_pkg::*;
#(
   parameter int IDX_W   = 15,
   parameter int ADDR_W  = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [63:0]       in_ptr,
   input  logic [IDX_W-1:0]  in_index,
   input  logic [ADDR_W-1:0] in_laddr,
   input  logic              in_fcl_en,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [1:0]        out_kind,
   output logic [ADDR_W-1:0] out_addr,
   output logic [1:0]        out_fault
);
   if (ADDR_W > 32 || ADDR_W <= BASE_LSB) begin : g_bad_addr_w
      $error("rootptr_xlate: ADDR_W out of range");
   end
   if (IDX_W < 1 || IDX_W > ADDR_W) begin : g_bad_idx_w
      $error("rootptr_xlate: IDX_W out of range");
   end

   dtype_e            dt;
   logic              sense_lo;
   logic [LIM_W-1:0]  limit;
   logic [ADDR_W-1:0] base;
   logic              viol;
   logic [ADDR_W-1:0] raw_addr;
   logic [FLT_W-1:0]  c_fault;
   kind_e             c_kind;
   logic [ADDR_W-1:0] c_addr;

   rootptr_fields #(.ADDR_W(ADDR_W)) u_fields (
      .ptr(in_ptr), .dt(dt), .sense_lo(sense_lo), .limit(limit), .base(base)
   );

   rootptr_bound #(.IDX_W(IDX_W)) u_bound (
      .idx(in_index), .limit(limit), .sense_lo(sense_lo), .dt(dt),
      .fcl_en(in_fcl_en), .violation(viol)
   );

   rootptr_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
      .dt(dt), .base(base), .laddr(in_laddr), .idx(in_index), .addr(raw_addr)
   );

   always_comb begin
      c_fault          = '0;
      c_fault[FLT_INV] = (dt == DT_INVALID);
      c_fault[FLT_LIM] = (dt != DT_INVALID) && viol;
      if (c_fault != '0) begin
         c_kind = KIND_FAULT;
         c_addr = '0;
      end else begin
         c_kind = (dt == DT_PAGE) ? KIND_PAGE : KIND_TABLE;
         c_addr = raw_addr;
      end
   end

   if (REG_OUT) begin : g_reg
      logic              vq;
      logic [1:0]        kind_q;
      logic [ADDR_W-1:0] addr_q;
      logic [FLT_W-1:0]  fault_q;
      logic              take;

      assign in_ready = !vq || out_ready;
      assign take     = in_valid && in_ready;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vq      <= 1'b0;
            kind_q  <= '0;
            addr_q  <= '0;
            fault_q <= '0;
         end else begin
            if (take) begin
               vq      <= 1'b1;
               kind_q  <= c_kind;
               addr_q  <= c_addr;
               fault_q <= c_fault;
            end else if (out_ready) begin
               vq <= 1'b0;
            end
         end
      end

      assign out_valid = vq;
      assign out_kind  = kind_q;
      assign out_addr  = addr_q;
      assign out_fault = fault_q;
   end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_kind  = c_kind;
      assign out_addr  = c_addr;
      assign out_fault = c_fault;
   end
endmodule

// File: rtl/rootptr_xlate_chk.sv
module rootptr_xlate_chk #(
   parameter int IDX_W   = 15,
   parameter int ADDR_W  = 32,
   parameter bit REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [63:0]       in_ptr,
   input logic              out_valid,
   input logic              out_ready,
   input logic [1:0]        out_kind,
   input logic [ADDR_W-1:0] out_addr,
   input logic [1:0]        out_fault
);
   AST_FAULT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $onehot0(out_fault)); // R10

   AST_FAULT_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_kind == 2'd2) |-> (out_addr == '0 && out_fault != 2'b00)); // R1

   AST_NO_FAULT_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_kind != 2'd2) |-> (out_fault == 2'b00 && out_kind != 2'd3)); // R2

   if (REG_OUT) begin : g_reg_chk
      AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && !out_ready) |=>
            (out_valid && $stable(out_addr) && $stable(out_kind) && $stable(out_fault))); // R11

      AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
         !out_valid |-> in_ready); // R11

      AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_ready) |=> out_valid); // R11

      AST_INVALID_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_ready && in_ptr[33:32] == 2'd0) |=>
            (out_kind == 2'd2 && out_fault == 2'b01)); // R1
   end
endmodule

bind rootptr_xlate rootptr_xlate_chk #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .REG_OUT(REG_OUT)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_ptr(in_ptr),
   .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
   .out_addr(out_addr), .out_fault(out_fault)
);

// File: tb/tb_rootptr_xlate.sv
module tb_rootptr_xlate;
   localparam int IDX_W  = 15;
   localparam int ADDR_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [63:0]       in_ptr = '0;
   logic [IDX_W-1:0]  in_index = '0;
   logic [ADDR_W-1:0] in_laddr = '0;
   logic              in_fcl_en = 1'b0;
   logic              out_valid;
   logic              out_ready = 1'b1;
   logic [1:0]        out_kind;
   logic [ADDR_W-1:0] out_addr;
   logic [1:0]        out_fault;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int ready_mode = 0;
   bit done = 1'b0;

   logic [1:0]  q_kind[$];
   logic [31:0] q_addr[$];
   logic [1:0]  q_fault[$];
   string       q_tag[$];
   string       cur_tag = "";

   bit          stalled = 1'b0;
   logic [1:0]  s_kind;
   logic [31:0] s_addr;
   logic [1:0]  s_fault;

   always #5 clk = ~clk;

   rootptr_xlate #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .REG_OUT(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_ptr(in_ptr), .in_index(in_index), .in_laddr(in_laddr), .in_fcl_en(in_fcl_en),
      .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
      .out_addr(out_addr), .out_fault(out_fault)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural reference of the requirements
   task automatic model(input logic [63:0] p, input int idx, input longint la, input bit fcl,
                        output logic [1:0] k, output logic [31:0] a, output logic [1:0] f);
      int     dt;
      int     lim;
      bit     lower;
      longint base;
      bit     bounded;
      bit     bad;
      dt    = int'(p[33:32]);
      lim   = int'(p[62:48]);
      lower = p[63];
      base  = longint'(p[31:4]) * 16;
      bounded = !(fcl && dt != 1);
      bad   = bounded && (lower ? (idx < lim) : (idx > lim));
      if (dt == 0) begin
         k = 2; a = 0; f = 2'b01;
      end else if (bad) begin
         k = 2; a = 0; f = 2'b10;
      end else if (dt == 1) begin
         k = 1; a = 32'((la + base) % 64'h1_0000_0000); f = 0;
      end else if (dt == 2) begin
         k = 0; a = 32'((base + longint'(idx) * 4) % 64'h1_0000_0000); f = 0;
      end else begin
         k = 0; a = 32'((base + longint'(idx) * 8) % 64'h1_0000_0000); f = 0;
      end
   endtask

   function automatic logic [63:0] mk(input bit lower, input int lim, input int dt,
                                      input logic [27:0] b28, input logic [17:0] junk);
      logic [63:0] p;
      p = '0;
      p[63]    = lower;
      p[62:48] = 15'(lim);
      p[47:34] = junk[17:4];
      p[33:32] = 2'(dt);
      p[31:4]  = b28;
      p[3:0]   = junk[3:0];
      return p;
   endfunction

   task automatic send(input logic [63:0] p, input int idx, input logic [31:0] la,
                       input bit fcl, input string tag);
      in_valid  = 1'b1;
      in_ptr    = p;
      in_index  = IDX_W'(idx);
      in_laddr  = la;
      in_fcl_en = fcl;
      cur_tag   = tag;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   // ready pattern driver
   always @(posedge clk) begin
      cyc <= cyc + 1;
      #1;
      if (ready_mode == 0) out_ready = 1'b1;
      else out_ready = ((cyc % 3) != 0) && ((cyc % 7) != 2);
   end

   // monitor: runs away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         logic [1:0]  ek;
         logic [31:0] ea;
         logic [1:0]  ef;
         if (stalled) begin
            check(out_valid && out_kind == s_kind && out_addr == s_addr && out_fault == s_fault,
                  "R11 hold under stall", longint'(out_addr), longint'(s_addr));
         end
         stalled = out_valid && !out_ready;
         s_kind = out_kind; s_addr = out_addr; s_fault = out_fault;
         if (out_valid && out_ready) begin
            if (q_kind.size() == 0) begin
               check(1'b0, "R11 unexpected result", 1, 0);
            end else begin
               ek = q_kind.pop_front(); ea = q_addr.pop_front(); ef = q_fault.pop_front();
               check(out_kind == ek, {q_tag[0], " kind"}, longint'(out_kind), longint'(ek));
               check(out_addr == ea, {q_tag[0], " addr"}, longint'(out_addr), longint'(ea));
               check(out_fault == ef, {q_tag[0], " fault"}, longint'(out_fault), longint'(ef));
               void'(q_tag.pop_front());
            end
         end
         if (in_valid && in_ready) begin
            model(in_ptr, int'(in_index), longint'(in_laddr), in_fcl_en, ek, ea, ef);
            q_kind.push_back(ek); q_addr.push_back(ea); q_fault.push_back(ef);
            q_tag.push_back(cur_tag);
         end
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R12 out_valid in reset", longint'(out_valid), 0);
      check(in_ready == 1'b1, "R12 in_ready in reset", longint'(in_ready), 1);
      @(posedge clk); #1;
      rst_n = 1'b1;
      @(posedge clk); #1;

      send(mk(0, 16'h7FFF, 0, 28'h0123456, 0), 3, 32'h1000, 0, "R1 invalid type");
      send(mk(0, 0, 0, 28'h0ABCDEF, 0), 5, 32'h0, 0, "R10 invalid beats limit");
      send(mk(0, 16, 2, 28'h0010000, 0), 16, 32'h0, 0, "R2 upper at bound");
      send(mk(0, 16, 2, 28'h0010000, 0), 17, 32'h0, 0, "R2 upper past bound");
      send(mk(1, 16, 3, 28'h0020000, 0), 16, 32'h0, 0, "R3 lower at bound");
      send(mk(1, 16, 3, 28'h0020000, 0), 15, 32'h0, 0, "R3 lower below bound");
      send(mk(0, 16'h7FFF, 2, 28'h0000100, 0), 16'h7FFF, 32'h0, 0, "R8 upper all ones");
      send(mk(1, 0, 3, 28'h0000100, 0), 0, 32'h0, 0, "R8 lower zero");
      send(mk(0, 16'h7FFF, 1, 28'h0012345, 0), 0, 32'h0000_1234, 0, "R4 page offset");
      send(mk(0, 16'h7FFF, 1, 28'hFFFFFFF, 0), 0, 32'h0000_0020, 0, "R4 page wrap");
      send(mk(0, 16'h7FFF, 2, 28'hFFFFFFF, 0), 100, 32'h0, 0, "R5 short wrap");
      send(mk(0, 16'h7FFF, 3, 28'h0400000, 0), 16'h7FFF, 32'h0, 0, "R6 long max index");
      send(mk(0, 0, 2, 28'h0003000, 0), 9, 32'h0, 1, "R7 lookup skips short");
      send(mk(1, 100, 3, 28'h0003000, 0), 9, 32'h0, 1, "R7 lookup skips long");
      send(mk(0, 0, 1, 28'h0003000, 0), 9, 32'h5000, 1, "R7 page still bounded");
      send(mk(0, 40, 2, 28'h0055500, 18'h3FFFF), 40, 32'h0, 0, "R9 junk bits short");
      send(mk(1, 40, 1, 28'h0055500, 18'h2A5A5), 41, 32'h7777, 0, "R9 junk bits page");

      ready_mode = 1;
      for (int i = 0; i < 400; i++) begin
         logic [63:0] p;
         p = {$urandom, $urandom};
         if (i % 5 == 0) p[62:48] = 15'(i * 37);
         send(p, int'($urandom % 32768), $urandom, 1'($urandom), "R11 random stall");
      end

      ready_mode = 0;
      repeat (10) @(posedge clk);
      check(q_kind.size() == 0, "R11 drained", longint'(q_kind.size()), 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule